// File: doc/BRIEF.md
# Subblock-Valid Write-Through Cache

This block is a direct-mapped data cache that sits between a load/store core and a word-addressed memory. Each line holds one tag but tracks validity per word, so a read miss brings in only the single word that was asked for, and the core resumes as soon as that word arrives. Other words of the same line fill later, on their own misses.

Writes never wait for memory. A write updates the cached word at once and is also forwarded to memory through a one-cycle write port. If the line already belongs to the write's tag, only that word's valid flag is set. If the line belongs to a different tag, the line is taken over: it gets the new tag, and only the written word stays valid. Because memory always has a current copy, dropping the old words loses nothing. A read miss to a line owned by another tag takes over the line in the same way when its word returns.

The address splits, from least to most significant, into byte offset, word-in-line, line index and tag. The byte offset is ignored: all accesses are whole words.

Top module: `sbc_cache`

## Requirements
- R1: After reset every word of every line is invalid, so the first read of any address misses. During reset and before the first request, `req_ready` is 1 and `rsp_valid`, `mem_rd_req` and `mem_wr_valid` are 0.
- R2: A read is a hit when the line's tag equals the address tag and that word's valid flag is set. A hit returns the stored word with `rsp_valid` high in the cycle after acceptance, and no memory read is issued.
- R3: A read that is not a hit raises `mem_rd_req` from the cycle after acceptance. `mem_rd_addr` holds the word-aligned request address, with byte offset bits zero, and does not change while the request is up. `req_ready` stays 0 until the reply arrives.
- R4: The cycle after `mem_rd_valid` is seen with `mem_rd_req` high, `rsp_valid` is 1 and `rsp_rdata` is the returned word. Only that word becomes valid: a neighbouring word of the same line that was invalid still misses.
- R5: A read miss to a line held by another tag retags the line, keeps only the fetched word valid, and clears all other words.
- R6: A write whose tag matches and whose word is valid replaces the word. The other words of the line keep their contents and validity.
- R7: A write whose tag matches and whose word is invalid stores the word and makes it valid, without any memory read.
- R8: A write whose tag differs from the line's tag stores the new tag, makes only the written word valid and invalidates every other word. Reads of the old tag then miss.
- R9: Every accepted write shows up in the next cycle on `mem_wr_valid`, `mem_wr_addr` (word-aligned) and `mem_wr_data`. It issues no memory read, and `req_ready` stays 1.
- R10: Address fields with the default parameters are: byte offset bits [1:0] (ignored), word-in-line bits [3:2], line index bits [6:4] and tag bits [15:7]. Two addresses with equal index and different tags share one line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Cache can accept a request this cycle |
| rsp_valid | output | 1 | Read data valid (one cycle) |
| rsp_rdata | output | DATA_W | Read data |
| mem_rd_req | output | 1 | One-word memory read request, held until reply |
| mem_rd_addr | output | ADDR_W | Word-aligned read address |
| mem_rd_valid | input | 1 | Memory read reply present |
| mem_rd_data | input | DATA_W | Memory read reply word |
| mem_wr_valid | output | 1 | Write-through word present (one cycle) |
| mem_wr_addr | output | ADDR_W | Word-aligned write address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The bench uses the defaults: 16-bit addresses, 32-bit words, 8 lines of 4 words. With these values a 0x80 address stride keeps the index and changes the tag, so line takeovers by both reads and writes can be reached in a few accesses. Misses that return data written earlier under a displaced tag show that write-through kept memory current. Memory replies come three cycles after each request, which holds the stall window open long enough to watch `req_ready` and the held read address.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } sbc_state_e;

    // Tag store update request
    typedef enum logic [1:0] {
        TU_NONE  = 2'd0,
        TU_SET   = 2'd1,
        TU_RETAG = 2'd2
    } sbc_tag_op_e;

endpackage

// File: rtl/sbc_tag_store.sv
module sbc_tag_store
    import sbc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int WORDS = 4,
    parameter int TAG_W = 9,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WORD_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [WORDS-1:0]  lk_valid,
    input  sbc_tag_op_e       up_op,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [TAG_W-1:0]  up_tag,
    input  logic [WORD_W-1:0] up_word
);

    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic             sel;
        logic [TAG_W-1:0] tag_d;
        logic [WORDS-1:0] vld_d;

        assign sel = (up_idx == IDX_W'(l));

        always_comb begin
            tag_d = tag_q[l];
            vld_d = vld_q[l];
            if (sel && up_op == TU_SET) begin
                vld_d[up_word] = 1'b1;
            end else if (sel && up_op == TU_RETAG) begin
                tag_d = up_tag;
                vld_d = WORDS'(1) << up_word;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[l] <= '0;
                vld_q[l] <= '0;
            end else begin
                tag_q[l] <= tag_d;
                vld_q[l] <= vld_d;
            end
        end
    end

    assign lk_tag   = tag_q[lk_idx];
    assign lk_valid = vld_q[lk_idx];

    // R8 / R5: a takeover leaves exactly one valid word and the new tag
    p_retag_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_op == TU_RETAG) |=>
            ($countones(vld_q[$past(up_idx)]) == 1) && (tag_q[$past(up_idx)] == $past(up_tag)));

    // R7: a set never clears other words
    p_set_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_op == TU_SET) |=>
            ((vld_q[$past(up_idx)] & $past(vld_q[up_idx])) == $past(vld_q[up_idx])));

endmodule

// File: rtl/sbc_data_store.sv
module sbc_data_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int WORD_W = $clog2(WORDS),
    localparam int DEPTH  = LINES * WORDS
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  w_idx,
    input  logic [WORD_W-1:0] w_word,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  r_idx,
    input  logic [WORD_W-1:0] r_word,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[{w_idx, w_word}] <= wdata;
        end
    end

    assign rdata = mem_q[{r_idx, r_word}];

endmodule

// File: rtl/sbc_cache.sv
module sbc_cache
    import sbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);

    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int WORD_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - BYTE_W - WORD_W - IDX_W;
    localparam int WLO    = BYTE_W;
    localparam int ILO    = BYTE_W + WORD_W;
    localparam int TLO    = BYTE_W + WORD_W + IDX_W;

    typedef struct packed {
        sbc_state_e        state;
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_data;
        logic              rd_req;
        logic [ADDR_W-1:0] miss_addr;
        logic              wr_valid;
        logic [ADDR_W-1:0] wr_addr;
        logic [DATA_W-1:0] wr_data;
    } regs_t;

    regs_t r_d, r_q;

    logic [ADDR_W-1:0] cur_addr;
    logic [TAG_W-1:0]  cur_tag, lk_tag;
    logic [IDX_W-1:0]  cur_idx;
    logic [WORD_W-1:0] cur_word;
    logic [WORDS-1:0]  lk_valid;
    logic              tag_match;
    logic              ds_we;
    logic [DATA_W-1:0] ds_wdata, ds_rdata;
    sbc_tag_op_e       tu_op;

    // During a fetch the pending miss address drives the lookup
    assign cur_addr  = (r_q.state == ST_FETCH) ? r_q.miss_addr : req_addr;
    assign cur_tag   = cur_addr[ADDR_W-1:TLO];
    assign cur_idx   = cur_addr[TLO-1:ILO];
    assign cur_word  = cur_addr[ILO-1:WLO];
    assign tag_match = (lk_tag == cur_tag);

    sbc_tag_store #(.LINES(LINES), .WORDS(WORDS), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cur_idx),
        .lk_tag   (lk_tag),
        .lk_valid (lk_valid),
        .up_op    (tu_op),
        .up_idx   (cur_idx),
        .up_tag   (cur_tag),
        .up_word  (cur_word)
    );

    sbc_data_store #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .we     (ds_we),
        .w_idx  (cur_idx),
        .w_word (cur_word),
        .wdata  (ds_wdata),
        .r_idx  (cur_idx),
        .r_word (cur_word),
        .rdata  (ds_rdata)
    );

    always_comb begin
        r_d           = r_q;
        r_d.rsp_valid = 1'b0;
        r_d.wr_valid  = 1'b0;
        ds_we         = 1'b0;
        ds_wdata      = req_wdata;
        tu_op         = TU_NONE;
        req_ready     = (r_q.state == ST_IDLE);

        if (r_q.state == ST_IDLE) begin
            if (req_valid && req_write) begin
                ds_we       = 1'b1;
                tu_op       = tag_match ? TU_SET : TU_RETAG;
                r_d.wr_valid = 1'b1;
                r_d.wr_addr  = {req_addr[ADDR_W-1:WLO], {BYTE_W{1'b0}}};
                r_d.wr_data  = req_wdata;
            end else if (req_valid) begin
                if (tag_match && lk_valid[cur_word]) begin
                    r_d.rsp_valid = 1'b1;
                    r_d.rsp_data  = ds_rdata;
                end else begin
                    r_d.state     = ST_FETCH;
                    r_d.rd_req    = 1'b1;
                    r_d.miss_addr = {req_addr[ADDR_W-1:WLO], {BYTE_W{1'b0}}};
                end
            end
        end else if (mem_rd_valid) begin
            ds_we         = 1'b1;
            ds_wdata      = mem_rd_data;
            tu_op         = tag_match ? TU_SET : TU_RETAG;
            r_d.rsp_valid = 1'b1;
            r_d.rsp_data  = mem_rd_data;
            r_d.rd_req    = 1'b0;
            r_d.state     = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid    = r_q.rsp_valid;
    assign rsp_rdata    = r_q.rsp_data;
    assign mem_rd_req   = r_q.rd_req;
    assign mem_rd_addr  = r_q.miss_addr;
    assign mem_wr_valid = r_q.wr_valid;
    assign mem_wr_addr  = r_q.wr_addr;
    assign mem_wr_data  = r_q.wr_data;

    // R3: core is stalled while a memory read is outstanding
    p_fetch_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !req_ready);

    // R3: read address is held until the reply
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr)));

    // R4: reply word is forwarded to the core one cycle later
    p_fill_forward_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && mem_rd_valid) |=> (rsp_valid && !mem_rd_req && rsp_rdata == $past(mem_rd_data)));

    // R9: every accepted write is passed through, aligned, without a read
    p_write_through_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=>
            (mem_wr_valid && !mem_rd_req && req_ready &&
             mem_wr_data == $past(req_wdata) &&
             mem_wr_addr == {$past(req_addr[ADDR_W-1:WLO]), {BYTE_W{1'b0}}}));

    // R2: no response appears without a request or a reply the cycle before
    p_rsp_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past((req_valid && req_ready && !req_write) || (mem_rd_req && mem_rd_valid)));

endmodule

// File: tb/sim_sbc_cache.sv
module sim_sbc_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, mem_rd_req, mem_wr_valid;
    logic [31:0] rsp_rdata, mem_wr_data;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    int lat_cnt = 0;
    logic [31:0] mem_model [logic [15:0]];

    always #4 clk = ~clk;

    sbc_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data)
    );

    function automatic logic [31:0] mem_val(input logic [15:0] a);
        if (mem_model.exists(a)) return mem_model[a];
        return 32'h5A00_0000 ^ {16'h0, a};
    endfunction

    // Memory: replies three cycles after a read request is seen
    always @(negedge clk) begin
        if (!rst_n || !mem_rd_req) begin
            lat_cnt      = 0;
            mem_rd_valid = 1'b0;
        end else begin
            lat_cnt = lat_cnt + 1;
            if (lat_cnt == 3) begin
                mem_rd_valid = 1'b1;
                mem_rd_data  = mem_val(mem_rd_addr);
            end else begin
                mem_rd_valid = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // One core access; exp_miss says whether a memory read must occur
    task automatic run_op(input logic wr, input logic [15:0] a, input logic [31:0] wd,
                          input logic exp_miss, input string rq);
        logic [15:0] al;
        logic [31:0] exp_d;
        bit          seen;
        logic [15:0] rd_a;
        bit          stall_ok;
        al = {a[15:2], 2'b00};
        exp_d = wr ? wd : mem_val(al);
        seen = 0; rd_a = '0; stall_ok = 1;
        @(negedge clk);
        check(req_ready == 1'b1, {rq, " ready before access"}, 32'(req_ready), 32'd1);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            // R9: write port one cycle after acceptance, no read, no stall
            check(mem_wr_valid == 1'b1, {rq, " R9 wr_valid"}, 32'(mem_wr_valid), 32'd1);
            check(mem_wr_addr == al, {rq, " R9 wr_addr"}, 32'(mem_wr_addr), 32'(al));
            check(mem_wr_data == wd, {rq, " R9 wr_data"}, mem_wr_data, wd);
            check(!mem_rd_req && req_ready, {rq, " R9 no fetch"}, 32'(mem_rd_req), 32'd0);
            if (mem_wr_valid) mem_model[mem_wr_addr] = mem_wr_data;
        end else begin
            for (int i = 0; i < 30; i++) begin
                if (rsp_valid) break;
                if (mem_rd_req) begin
                    seen = 1; rd_a = mem_rd_addr;
                    if (req_ready) stall_ok = 0;
                end
                @(negedge clk);
            end
            check(rsp_valid == 1'b1, {rq, " rsp_valid"}, 32'(rsp_valid), 32'd1);
            check(rsp_rdata == exp_d, {rq, " rsp_rdata"}, rsp_rdata, exp_d);
            check(seen == exp_miss, {rq, " miss expectation"}, 32'(seen), 32'(exp_miss));
            if (exp_miss) begin
                check(rd_a == al, {rq, " R3 R10 mem_rd_addr"}, 32'(rd_a), 32'(al));
                check(stall_ok, {rq, " R3 stall"}, 32'(stall_ok), 32'd1);
            end
        end
    endtask

    // {wr, addr, wdata, exp_miss, requirement number}
    localparam int NV = 19;
    localparam logic [57:0] VECS [NV] = '{
        {1'b0, 16'h0080, 32'h0,         1'b1, 8'd1},  // R1 cold miss
        {1'b0, 16'h0080, 32'h0,         1'b0, 8'd2},  // R2 hit
        {1'b0, 16'h0084, 32'h0,         1'b1, 8'd4},  // R4 neighbour not filled
        {1'b0, 16'h0084, 32'h0,         1'b0, 8'd2},
        {1'b1, 16'h0080, 32'hAAAA_0001, 1'b0, 8'd6},  // R6 match, valid
        {1'b0, 16'h0080, 32'h0,         1'b0, 8'd6},
        {1'b0, 16'h0084, 32'h0,         1'b0, 8'd6},  // R6 neighbour kept
        {1'b1, 16'h0088, 32'hBBBB_0002, 1'b0, 8'd7},  // R7 match, invalid
        {1'b0, 16'h0088, 32'h0,         1'b0, 8'd7},
        {1'b1, 16'h0100, 32'hCCCC_0003, 1'b0, 8'd8},  // R8 takeover by write
        {1'b0, 16'h0100, 32'h0,         1'b0, 8'd8},
        {1'b0, 16'h0104, 32'h0,         1'b1, 8'd8},  // R8 others cleared
        {1'b0, 16'h0080, 32'h0,         1'b1, 8'd9},  // R9 memory kept AAAA; R5 takeover by read
        {1'b0, 16'h0088, 32'h0,         1'b1, 8'd5},  // R5 cleared BBBB word
        {1'b0, 16'h0104, 32'h0,         1'b1, 8'd5},  // R5 second takeover
        {1'b0, 16'h0093, 32'h0,         1'b1, 8'd10}, // R10 byte offset ignored
        {1'b0, 16'h0090, 32'h0,         1'b0, 8'd10},
        {1'b1, 16'h00A3, 32'hDDDD_0004, 1'b0, 8'd10}, // R10 aligned write address
        {1'b0, 16'h00A0, 32'h0,         1'b0, 8'd10}
    };

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs during reset
        check(req_ready == 1'b1, "R1 ready in reset", 32'(req_ready), 32'd1);
        check(!rsp_valid && !mem_rd_req && !mem_wr_valid, "R1 outputs idle in reset",
              {29'd0, rsp_valid, mem_rd_req, mem_wr_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_op(VECS[v][57], VECS[v][56:41], VECS[v][40:9], VECS[v][8],
                   $sformatf("R%0d vec%0d", VECS[v][7:0], v));
        end

        // R1: reset clears validity of previously filled words
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!rsp_valid && !mem_rd_req && !mem_wr_valid && req_ready, "R1 outputs after reset",
              {28'd0, rsp_valid, mem_rd_req, mem_wr_valid, req_ready}, 32'd1);
        rst_n = 1'b1;
        run_op(1'b0, 16'h0090, 32'h0, 1'b1, "R1 post-reset miss");
        run_op(1'b0, 16'h00A0, 32'h0, 1'b1, "R1 post-reset miss written word");

        // R10: same index, different tag conflicts; different index does not
        run_op(1'b0, 16'h0110, 32'h0, 1'b1, "R10 index conflict");
        run_op(1'b0, 16'h00A0, 32'h0, 1'b0, "R10 other index undisturbed");
        run_op(1'b0, 16'h0090, 32'h0, 1'b1, "R10 displaced tag misses");

        finish_run();
    end

endmodule